// File: doc/BRIEF.md
# Integer Compare Flag Unit

This block compares two signed or unsigned integer operands taken from a bank of sixteen 64-bit registers. It returns the outcome as four condition flags packed into the top nibble of a 32-bit word, ready for a host core to load into its status register. An instruction word selects the two source registers and a sub-opcode. The sub-opcode picks between a 32-bit compare, which uses only the lower half of each register, and a 64-bit compare, which uses the whole register.

The unit drives the two register indices straight from the instruction word to the read ports of the register file, and takes the read data back in the same cycle. It subtracts B from A and derives the negative, zero, carry and overflow flags from the sign bits of the operands and the difference. The flag word and a one-cycle done strobe are registered, so they appear one clock after the request. A sub-opcode other than the two compare codes raises an illegal flag and returns an all-zero flag word.

Top module: `cfu_top`

## Requirements
- R1: While reset (rst_n low) is applied and in the first cycle after it, flags_o, done_o and illegal_o are all zero.
- R2: rf_addr_a_o always equals instr_i[19:16] and rf_addr_b_o always equals instr_i[3:0], with no clock delay.
- R3: done_o is high for exactly the one cycle after each cycle in which req_i is high, and low otherwise.
- R4: Sub-opcode instr_i[7:5] = 4 compares the lower 32 bits (bits 31:0) of A and B; the upper halves have no effect on the result.
- R5: Sub-opcode instr_i[7:5] = 5 compares full 64-bit operands. The register's upper half, on data bits 63:32, is the most significant word.
- R6: Z is set when A minus B is zero in the selected width, and N is set when the top bit of that difference is one.
- R7: C is set when (A is negative and B is not), or (A is negative and the difference is not), or (B is not negative and the difference is not), with sign taken as the top bit. This equals A >= B when the operands are read as unsigned values.
- R8: V is set when the signed subtraction overflows: A negative, B non-negative and difference non-negative, or A non-negative, B negative and difference negative.
- R9: The flag word carries N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. Bits 27:0 are zero.
- R10: Any sub-opcode other than 4 or 5 sets illegal_o and returns flags_o = 0 together with the done strobe. A legal request clears illegal_o.
- R11: Between requests, flags_o and illegal_o hold the values of the last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Compare request strobe |
| instr_i | input | 32 | Instruction word: source indices and sub-opcode |
| rf_addr_a_o | output | 4 | Read index for operand A |
| rf_addr_b_o | output | 4 | Read index for operand B |
| rf_data_a_i | input | 64 | Register A contents, upper half in bits 63:32 |
| rf_data_b_i | input | 64 | Register B contents, upper half in bits 63:32 |
| flags_o | output | 32 | Packed NZCV flag word |
| done_o | output | 1 | Result valid, one cycle after request |
| illegal_o | output | 1 | Last request had an unknown sub-opcode |

## Verification
The bench builds the unit with its defaults: a 32-bit half width and sixteen registers. At that size every sign boundary can be reached, both at bit 31 and at bit 63, including the most-negative minus one and the most-positive minus minus one. Directed registers whose lower halves match but whose upper halves differ show whether the 32-bit mode leaks the upper bits and whether the 64-bit mode forms its word order correctly. Random register contents and instruction words, with the unused instruction bits randomised too, cover the remaining flag combinations and all eight sub-opcodes.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  // Instruction field positions, fixed by the host encoding
  localparam int SRC_A_LSB = 16;
  localparam int SRC_B_LSB = 0;
  localparam int SUBOP_LSB = 5;
  localparam int SUBOP_W   = 3;
  localparam int FLAG_LSB  = 28;

  typedef enum logic [SUBOP_W-1:0] {
    SUBOP_CMP_NARROW = 3'd4,
    SUBOP_CMP_WIDE   = 3'd5
  } subop_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Place the four flags at the top of a host-width word
  function automatic logic [31:0] pack_flags(input nzcv_t f);
    logic [31:0] w;
    w = '0;
    w[FLAG_LSB +: 4] = f;
    return w;
  endfunction
endpackage

// File: rtl/cfu_decode.sv
module cfu_decode #(
  parameter int IDX_W = 4
) (
  input  logic [31:0]      instr,
  output logic [IDX_W-1:0] src_a,
  output logic [IDX_W-1:0] src_b,
  output logic             sel_wide,
  output logic             bad_op
);
  import cfu_pkg::*;

  logic [SUBOP_W-1:0] subop;
  logic               unused_bits;

  assign src_a = instr[SRC_A_LSB +: IDX_W];
  assign src_b = instr[SRC_B_LSB +: IDX_W];
  assign subop = instr[SUBOP_LSB +: SUBOP_W];
  assign unused_bits = ^{instr[31:SRC_A_LSB+IDX_W], instr[SRC_A_LSB-1:SUBOP_LSB+SUBOP_W],
                         instr[SUBOP_LSB-1:SRC_B_LSB+IDX_W]};

  always_comb begin
    sel_wide = 1'b0;
    bad_op   = 1'b0;
    case (subop)
      SUBOP_CMP_NARROW: sel_wide = 1'b0;
      SUBOP_CMP_WIDE:   sel_wide = 1'b1;
      default:          bad_op   = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfu_flags.sv
module cfu_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output cfu_pkg::nzcv_t flags
);
  logic [W-1:0] diff;
  logic         a_neg, b_neg, d_neg;

  assign diff  = op_a - op_b;
  assign a_neg = op_a[W-1];
  assign b_neg = op_b[W-1];
  assign d_neg = diff[W-1];

  assign flags.n = d_neg;
  assign flags.z = (diff == '0);
  assign flags.c = (a_neg & ~b_neg) | (a_neg & ~d_neg) | (~b_neg & ~d_neg);
  assign flags.v = (a_neg & ~b_neg & ~d_neg) | (~a_neg & b_neg & d_neg);
endmodule

// File: rtl/cfu_top.sv
module cfu_top #(
  parameter int HALF_W  = 32,
  parameter int REG_CNT = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [31:0]           instr_i,
  output logic [$clog2(REG_CNT)-1:0] rf_addr_a_o,
  output logic [$clog2(REG_CNT)-1:0] rf_addr_b_o,
  input  logic [2*HALF_W-1:0]   rf_data_a_i,
  input  logic [2*HALF_W-1:0]   rf_data_b_i,
  output logic [31:0]           flags_o,
  output logic                  done_o,
  output logic                  illegal_o
);
  import cfu_pkg::*;

  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int N_MODES = 2;

  logic   sel_wide, bad_op;
  nzcv_t  mode_flags [N_MODES];
  nzcv_t  picked;
  logic [31:0] word_nxt;

  cfu_decode #(.IDX_W(IDX_W)) u_dec (
    .instr   (instr_i),
    .src_a   (rf_addr_a_o),
    .src_b   (rf_addr_b_o),
    .sel_wide(sel_wide),
    .bad_op  (bad_op)
  );

  // Mode 0 uses the lower half, mode 1 the whole register
  for (genvar g = 0; g < N_MODES; g++) begin : g_mode
    localparam int W = HALF_W * (g + 1);
    cfu_flags #(.W(W)) u_flags (
      .op_a (rf_data_a_i[W-1:0]),
      .op_b (rf_data_b_i[W-1:0]),
      .flags(mode_flags[g])
    );
  end

  assign picked   = sel_wide ? mode_flags[1] : mode_flags[0];
  assign word_nxt = bad_op ? 32'd0 : pack_flags(picked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o   <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        flags_o   <= word_nxt;
        illegal_o <= bad_op;
      end
    end
  end
endmodule

// File: rtl/cfu_check.sv
module cfu_check (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic [31:0] flags_o,
  input logic        done_o,
  input logic        illegal_o
);
  // R3: request answered in the next cycle
  assert_done_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);
  // R3: no strobe without a request
  assert_no_spurious_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(req_i));
  // R9: only the top nibble may be set
  assert_low_bits_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[27:0] == 28'd0);
  // R10: illegal result carries no flags
  assert_illegal_zero_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> flags_o == 32'd0);
  // R6: a zero difference has a clear top bit
  assert_zn_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_o[31] && flags_o[30]));
  // R7: equal operands imply no borrow
  assert_zero_sets_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[30] |-> flags_o[29]);
  // R11: outputs hold while idle
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(flags_o) && $stable(illegal_o)));
endmodule

bind cfu_top cfu_check u_check (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .flags_o  (flags_o),
  .done_o   (done_o),
  .illegal_o(illegal_o)
);

// File: tb/cfu_top_test.sv
module cfu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  addr_a, addr_b;
  logic [63:0] data_a, data_b;
  logic [31:0] flags;
  logic        done, illegal;
  logic [63:0] regs [16];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign data_a = regs[addr_a];
  assign data_b = regs[addr_b];

  cfu_top uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .instr_i(instr),
    .rf_addr_a_o(addr_a), .rf_addr_b_o(addr_b),
    .rf_data_a_i(data_a), .rf_data_b_i(data_b),
    .flags_o(flags), .done_o(done), .illegal_o(illegal)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  // Expected flag word, via wide signed arithmetic and unsigned compare
  function automatic logic [31:0] expect_word(input logic [63:0] a, input logic [63:0] b,
                                              input bit wide);
    logic signed [65:0] sd;
    logic [63:0] r;
    bit n, z, c, v;
    if (wide) begin
      sd = $signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b});
      r = sd[63:0];
      v = (sd > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (sd < -66'sh0_8000_0000_0000_0000);
      n = r[63]; z = (r == 0); c = (a >= b);
    end else begin
      sd = $signed({{34{a[31]}}, a[31:0]}) - $signed({{34{b[31]}}, b[31:0]});
      r = {32'd0, sd[31:0]};
      v = (sd > 66'sh7FFF_FFFF) || (sd < -66'sh8000_0000);
      n = r[31]; z = (r[31:0] == 0); c = (a[31:0] >= b[31:0]);
    end
    return {n, z, c, v, 28'd0};
  endfunction

  function automatic logic [31:0] mk(input logic [2:0] op, input logic [3:0] a,
                                     input logic [3:0] b, input logic [31:0] noise);
    logic [31:0] w;
    w = noise;
    w[19:16] = a; w[7:5] = op; w[3:0] = b;
    return w;
  endfunction

  logic [31:0] last_flags;
  logic        last_illegal;

  task automatic issue(input logic [31:0] iw);
    logic [31:0] exp;
    logic [2:0] op;
    op = iw[7:5];
    @(negedge clk);
    req = 1'b1; instr = iw;
    #0.5;
    check("R2 addr a", {28'd0, addr_a}, {28'd0, iw[19:16]});
    check("R2 addr b", {28'd0, addr_b}, {28'd0, iw[3:0]});
    if (op == 3'd4)      exp = expect_word(regs[iw[19:16]], regs[iw[3:0]], 1'b0); // R4
    else if (op == 3'd5) exp = expect_word(regs[iw[19:16]], regs[iw[3:0]], 1'b1); // R5
    else                 exp = 32'd0;                                             // R10
    @(negedge clk);
    req = 1'b0; instr = $urandom;
    check("R3 done after request", {31'd0, done}, 32'd1);
    check("R6 R7 R8 R9 flag word", flags, exp);
    check("R10 illegal flag", {31'd0, illegal}, {31'd0, (op != 3'd4 && op != 3'd5)});
    last_flags = flags; last_illegal = illegal;
    @(negedge clk);
    check("R3 single strobe", {31'd0, done}, 32'd0);
    check("R11 flags held", flags, last_flags);
    check("R11 illegal held", {31'd0, illegal}, {31'd0, last_illegal});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) regs[i] = {$urandom, $urandom};
    regs[0] = 64'h0;
    regs[1] = 64'h1;
    regs[2] = 64'h0000_0000_8000_0000;
    regs[3] = 64'h0000_0000_7FFF_FFFF;
    regs[4] = 64'h8000_0000_0000_0000;
    regs[5] = 64'h7FFF_FFFF_FFFF_FFFF;
    regs[6] = 64'hFFFF_0000_0000_0000;
    regs[7] = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    check("R1 reset illegal", {31'd0, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset flags", flags, 32'd0);
    check("R1 after reset done", {31'd0, done}, 32'd0);

    // R4: upper halves differ, lower halves equal -> Z and C
    issue(mk(3'd4, 4'd6, 4'd0, 32'h0));
    check("R4 narrow ignores upper half", flags, 32'h6000_0000);
    // R5: same registers differ in the wide compare, A negative
    issue(mk(3'd5, 4'd6, 4'd0, 32'h0));
    check("R5 wide uses upper half", flags, 32'hA000_0000);
    // R8: most-negative minus one overflows in 32 bits
    issue(mk(3'd4, 4'd2, 4'd1, 32'h0));
    check("R8 narrow overflow", flags, 32'h3000_0000);
    // R6 R7: zero minus one is negative with borrow
    issue(mk(3'd4, 4'd0, 4'd1, 32'h0));
    check("R6 R7 negative borrow", flags, 32'h8000_0000);
    // R8: wide overflow in both directions
    issue(mk(3'd5, 4'd4, 4'd5, 32'h0));
    check("R8 wide overflow neg-pos", flags, 32'h3000_0000);
    issue(mk(3'd5, 4'd5, 4'd4, 32'h0));
    check("R8 wide overflow pos-neg", flags, 32'h9000_0000);
    issue(mk(3'd4, 4'd3, 4'd7, 32'h0));
    issue(mk(3'd5, 4'd7, 4'd7, 32'h0));
    check("R6 wide equal", flags, 32'h6000_0000);
    // R10: every illegal sub-opcode, then a legal one clears it
    for (int op = 0; op < 8; op++) begin
      if (op != 4 && op != 5) issue(mk(3'(op), 4'd0, 4'd1, $urandom));
    end
    issue(mk(3'd4, 4'd1, 4'd0, 32'h0));
    check("R10 legal clears illegal", {31'd0, illegal}, 32'd0);

    // Random register contents and instruction words
    for (int k = 0; k < 400; k++) begin
      logic [2:0] op;
      if (k % 50 == 0)
        for (int i = 8; i < 16; i++) regs[i] = {$urandom, $urandom};
      op = ($urandom % 8 < 6) ? 3'(4 + ($urandom % 2)) : 3'($urandom);
      issue(mk(op, 4'($urandom), 4'($urandom), $urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule